// File: doc/BRIEF.md
# Memory ECC Fault Status Register

This block keeps a record of error-correction outcomes from a memory read path. For each read, the read path sends three one-cycle strobes. One marks a single-bit error that was corrected. One marks a double-bit error that could not be corrected. One marks an array read that was tried while a program or erase command was still running. The block turns these strobes into two sticky flags. Software reads the flags and clears them through an 8-bit register on a simple strobe bus.

The strobes first pass through a qualification stage, which adds one clock of lag. A register read in the cycle right after the faulting read therefore still returns the old flags. A new fault is recorded only when both flags are clear, so the first fault is kept until software clears it. A configuration input suppresses single-bit reporting. The single-bit flag, gated by an enable input, drives an interrupt line.

Top module: `ecc_fault_status`

## Requirements
- R1: The status register reads as 8 bits. Bit 1 is the double-bit flag, bit 0 is the single-bit flag, and bits 7..2 always read 0. Bus reads that do not hit the register address return 0.
- R2: After reset, both flags are 0 and the interrupt output is 0.
- R3: A bus write to the register address with a data bit at 1 clears the matching flag. A data bit at 0 leaves its flag alone. Writes to bits 7..2 and writes to other addresses change nothing, and a write never sets a flag.
- R4: An uncorrectable-fault strobe sets the double-bit flag.
- R5: A busy-read strobe sets the double-bit flag. It also sets the single-bit flag when the ignore-single input is 0.
- R6: A corrected-fault strobe sets the single-bit flag only when the ignore-single input is 0. The ignore-single input is sampled in the same cycle as the strobe.
- R7: When the corrected-fault strobe and the uncorrectable-fault strobe arrive in the same cycle, only the double-bit flag is set.
- R8: A strobe changes the flags two clock edges after the strobe cycle. A read in the cycle right after the strobe returns the old flags.
- R9: A fault is recorded only if both flags are clear once that cycle's bus clear has been applied. Otherwise the fault is dropped.
- R10: If a clear write lands on the same edge at which a qualified fault updates the flags, the fault is still recorded.
- R11: The interrupt output equals the single-bit flag ANDed with the interrupt-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_fault | input | 1 | Strobe: corrected single-bit error on this read |
| uncorr_fault | input | 1 | Strobe: uncorrectable double-bit error on this read |
| busy_read | input | 1 | Strobe: array read tried while a command is running |
| ignore_single | input | 1 | Suppresses single-bit reporting when 1 |
| single_irq_en | input | 1 | Enables the single-bit interrupt |
| bus_addr | input | 4 | Local register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read-strobe cycle |
| single_irq | output | 1 | Single-bit fault interrupt |

## Verification
The key overlap is a software clear and a fault update reaching the flag storage on the same clock edge. The bench first sets a flag. It then drives a fresh fault strobe, and in the next cycle writes a clear to the register. Because of the one-cycle lag, the clear and the pending fault meet at the same edge. The case passes only if the flag reads back as set afterwards. A second overlap also gets its own check: two fault strobes in the same cycle, where only the double-bit flag may be set.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NFLAG   = 2;
  localparam int unsigned BIT_SGL = 0;
  localparam int unsigned BIT_DBL = 1;

  typedef struct packed {
    logic dbl;
    logic sgl;
  } fault_pend_t;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ecc_fault_qual.sv
module ecc_fault_qual
  import ecc_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        corr_fault,
  input  logic        uncorr_fault,
  input  logic        busy_read,
  input  logic        ignore_single,
  output fault_pend_t pend_q
);
  fault_pend_t pend_d;

  // Double-bit outranks single-bit; a busy read counts as both.
  always_comb begin
    pend_d.dbl = uncorr_fault | busy_read;
    pend_d.sgl = ~ignore_single & (busy_read | (corr_fault & ~uncorr_fault));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ecc_flag_store.sv
module ecc_flag_store
  import ecc_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fault_pend_t      pend,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags_q
);
  logic [NFLAG-1:0] after_clr;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flags_d;
  logic             capture_ok;
  logic             flags_en;

  always_comb begin
    after_clr            = flags_q & ~clr_mask;
    capture_ok           = (after_clr == '0);
    set_vec              = '0;
    set_vec[BIT_DBL]     = pend.dbl;
    set_vec[BIT_SGL]     = pend.sgl;
    flags_d              = after_clr | (capture_ok ? set_vec : '0);
    flags_en             = (|clr_mask) | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/ecc_bus_regif.sv
module ecc_bus_regif
  import ecc_stat_pkg::*;
#(
  parameter int unsigned        AW       = 4,
  parameter logic [AW-1:0]      REG_ADDR = '0
) (
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] clr_mask,
  output logic [REG_W-1:0] bus_rdata
);
  logic hit;

  always_comb begin
    hit       = (bus_addr == REG_ADDR);
    clr_mask  = (bus_wr && hit) ? bus_wdata[NFLAG-1:0] : '0;
    bus_rdata = '0;
    if (bus_rd && hit) bus_rdata[NFLAG-1:0] = flags;
  end
endmodule

// File: rtl/ecc_fault_status.sv
module ecc_fault_status
  import ecc_stat_pkg::*;
#(
  parameter int unsigned   AW       = 4,
  parameter logic [AW-1:0] REG_ADDR = 4'h7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             corr_fault,
  input  logic             uncorr_fault,
  input  logic             busy_read,
  input  logic             ignore_single,
  input  logic             single_irq_en,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             single_irq
);
  logic             rst_n_sync;
  fault_pend_t      pend_q;
  logic [NFLAG-1:0] clr_mask;
  logic [NFLAG-1:0] flags_q;

  ecc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  ecc_fault_qual u_qual (
    .clk(clk), .rst_n(rst_n_sync),
    .corr_fault(corr_fault), .uncorr_fault(uncorr_fault),
    .busy_read(busy_read), .ignore_single(ignore_single),
    .pend_q(pend_q)
  );

  ecc_flag_store u_flags (
    .clk(clk), .rst_n(rst_n_sync),
    .pend(pend_q), .clr_mask(clr_mask), .flags_q(flags_q)
  );

  ecc_bus_regif #(.AW(AW), .REG_ADDR(REG_ADDR)) u_regif (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .flags(flags_q),
    .clr_mask(clr_mask), .bus_rdata(bus_rdata)
  );

  assign single_irq = flags_q[BIT_SGL] & single_irq_en;
endmodule

// File: rtl/ecc_fault_status_chk.sv
module ecc_fault_status_chk (
  input logic       clk,
  input logic       rst_n_sync,
  input logic [1:0] flags_q,
  input logic       pend_dbl,
  input logic       pend_sgl,
  input logic [1:0] clr_mask,
  input logic [7:0] bus_rdata,
  input logic       single_irq
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    bus_rdata[7:2] == 6'b0); // R1

  AST_DBL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(flags_q[1]) |-> $past(pend_dbl)); // R4

  AST_SGL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(flags_q[0]) |-> $past(pend_sgl)); // R6

  AST_DBL_STICKY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (flags_q[1] && !clr_mask[1]) |=> flags_q[1]); // R3

  AST_SGL_STICKY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (flags_q[0] && !clr_mask[0]) |=> flags_q[0]); // R3

  AST_BLOCKED_WHILE_SET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (flags_q[1] && !clr_mask[1] && !flags_q[0]) |=> !flags_q[0]); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    single_irq |-> flags_q[0]); // R11
endmodule

bind ecc_fault_status ecc_fault_status_chk u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .flags_q(flags_q),
  .pend_dbl(pend_q.dbl), .pend_sgl(pend_q.sgl), .clr_mask(clr_mask),
  .bus_rdata(bus_rdata), .single_irq(single_irq)
);

// File: tb/ecc_fault_status_tb.sv
module ecc_fault_status_tb;
  localparam logic [3:0] RADDR = 4'h7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       corr_fault = 1'b0, uncorr_fault = 1'b0, busy_read = 1'b0;
  logic       ignore_single = 1'b0, single_irq_en = 1'b1;
  logic [3:0] bus_addr = RADDR;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       single_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_fault_status u_dut (
    .clk(clk), .rst_n(rst_n), .corr_fault(corr_fault), .uncorr_fault(uncorr_fault),
    .busy_read(busy_read), .ignore_single(ignore_single), .single_irq_en(single_irq_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .single_irq(single_irq)
  );

  // {busy, uncorr, corr, ignore, wr, wdata[7:0], expected flags[1:0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {3'b001, 1'b0, 1'b0, 8'h00, 2'b01},  // R6 corrected fault
    {3'b000, 1'b0, 1'b1, 8'h01, 2'b00},  // R3 clear bit 0
    {3'b010, 1'b0, 1'b0, 8'h00, 2'b10},  // R4 uncorrectable fault
    {3'b001, 1'b0, 1'b0, 8'h00, 2'b10},  // R9 blocked while flag set
    {3'b000, 1'b0, 1'b1, 8'h02, 2'b00},  // R3 clear bit 1
    {3'b011, 1'b0, 1'b0, 8'h00, 2'b10},  // R7 both strobes
    {3'b000, 1'b0, 1'b1, 8'h03, 2'b00},  // R3 clear both
    {3'b100, 1'b0, 1'b0, 8'h00, 2'b11},  // R5 busy read
    {3'b000, 1'b0, 1'b1, 8'h01, 2'b10},  // R3 clear only bit 0
    {3'b010, 1'b0, 1'b1, 8'h00, 2'b10},  // R3/R9 write 0, event dropped
    {3'b000, 1'b0, 1'b1, 8'hFE, 2'b00},  // R3 upper bits ignored, bit 1 cleared
    {3'b001, 1'b1, 1'b0, 8'h00, 2'b00},  // R6 suppressed
    {3'b100, 1'b1, 1'b0, 8'h00, 2'b10},  // R5 busy read with ignore
    {3'b000, 1'b0, 1'b1, 8'hFF, 2'b00}   // R3 clear all
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    corr_fault = 0; uncorr_fault = 0; busy_read = 0;
    bus_wr = 0; bus_rd = 0; bus_wdata = 8'h00; bus_addr = RADDR;
  endtask

  task automatic read_chk(input string req, input logic [1:0] exp);
    bus_rd = 1'b1; bus_addr = RADDR;
    #2;
    chk(req, bus_rdata, {6'b0, exp});
    chk({req, " irq"}, {7'b0, single_irq}, {7'b0, exp[0] & single_irq_en});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic c, input logic u, input logic b);
    corr_fault = c; uncorr_fault = u; busy_read = b;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk("R2 reset", 2'b00);

    for (int i = 0; i < NV; i++) begin
      {busy_read, uncorr_fault, corr_fault} = VEC[i][14:12];
      ignore_single = VEC[i][11];
      bus_wr        = VEC[i][10];
      bus_wdata     = VEC[i][9:2];
      @(negedge clk);
      idle();
      ignore_single = 1'b0;
      @(negedge clk);
      read_chk($sformatf("R3/R4/R5/R6/R7/R9 vec %0d", i), VEC[i][1:0]);
    end

    // R8: one-cycle lag on the flag storage
    pulse(1, 0, 0);
    read_chk("R8 lag read", 2'b00);
    read_chk("R8 settled", 2'b01);

    // R10: clear and pending fault on the same edge
    pulse(1, 0, 0);
    bus_wr = 1'b1; bus_wdata = 8'h01;
    @(negedge clk);
    idle();
    read_chk("R10 set wins", 2'b01);

    // R11: interrupt disabled
    single_irq_en = 1'b0;
    #2;
    chk("R11 irq masked", {7'b0, single_irq}, 8'h00);
    single_irq_en = 1'b1;
    #2;
    chk("R11 irq enabled", {7'b0, single_irq}, 8'h01);

    // R3: write to another address is ignored
    bus_wr = 1'b1; bus_wdata = 8'hFF; bus_addr = 4'h3;
    @(negedge clk);
    idle();
    read_chk("R3 other addr write", 2'b01);

    // R1: read at another address returns 0
    bus_rd = 1'b1; bus_addr = 4'h2;
    #2;
    chk("R1 other addr read", bus_rdata, 8'h00);
    @(negedge clk);
    idle();

    // R2: reset clears flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk("R2 re-reset", 2'b00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule